// File: doc/BRIEF.md
# Periodic Driver Impedance Calibrator

This block keeps the 5-bit strength code of an output driver close to a target code. The target code comes from an external comparator. A free-running timer starts an evaluation at fixed intervals. Each evaluation prepares a new code that is at most one step away from the code the driver is using now. The prepared code is held aside. It reaches the driver only in a cycle where the driver is not driving the pad, so no glitch appears on a live output.

The driver is treated as high-impedance in three cases: the cycle is a write, the cycle is a deselect, or the output enable is high (inactive). Alongside the tracking, a power-up timer counts a fixed settling period. After that period, the block waits for a transition of the output from driving to high-impedance. It then raises a status flag saying that calibration after power-up is complete.

Top module: `drv_imp_cal`

## Requirements
- R1: An evaluation takes place at every 64th rising clock edge after reset is released, that is, at edges 64, 128, 192, and so on. At that edge the prepared code is computed from the applied code and from the target present at that edge.
- R2: An evaluation prepares the applied code plus one if the target is larger, minus one if it is smaller, and no change if they are equal. The applied code never changes by more than one per edge.
- R3: The applied code stays within 0 to 31. With the target at 31 it settles at 31, with the target at 0 it settles at 0, and it never wraps between the two ends.
- R4: A prepared change is applied only at an edge where at least one of wr_cyc, desel_cyc and oe_hi is 1. That edge takes the code to the prepared value.
- R5: A prepared change waits while the driver keeps driving, however long that lasts. A new evaluation replaces any waiting change, so changes never add up.
- R6: No change is applied at an evaluation edge, even inside a high-impedance window. The change prepared there is applied at a later high-impedance edge.
- R7: While reset is active, drv_code is 16 and cal_done is 0, and nothing is waiting to be applied.
- R8: cal_done rises only at an edge after the 4096th edge since reset, and only when the high-impedance condition is 1 at that edge and was 0 at the edge before. A window held high through the end of the settling period does not count. Before the first edge the condition counts as 1.
- R9: Once cal_done is 1 it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| tgt_code | input | 5 | Target strength code from the comparator |
| wr_cyc | input | 1 | Current cycle is a write (driver off) |
| desel_cyc | input | 1 | Current cycle is a deselect (driver off) |
| oe_hi | input | 1 | Output enable inactive (driver off) |
| drv_code | output | 5 | Strength code applied to the driver |
| cal_done | output | 1 | Power-up calibration complete |

## Verification
The assertions assume that all inputs are stable around each rising edge and that reset is held for at least one edge before checking starts. They also assume a nonzero evaluation period and a settling period of at least one cycle, which the defaults meet. The bench changes inputs only at falling edges. It mixes long driving stretches, single-cycle windows placed exactly on and just after an evaluation edge, a window held high through the end of the settling period, and pseudo-random stretches. Targets are taken only from the 5-bit range, so the saturation checks exercise the ends of the code range through legal target values.

// File: rtl/drvcal_pkg.sv
package drvcal_pkg;
  localparam int CODE_W   = 5;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  typedef logic [CODE_W-1:0] code_t;

  // One step from cur toward tgt, clamped to the code range.
  function automatic code_t step_toward(input code_t cur, input code_t tgt);
    code_t r;
    r = cur;
    if (tgt > cur && cur != code_t'(CODE_MAX)) r = cur + code_t'(1);
    else if (tgt < cur && cur != code_t'(0))   r = cur - code_t'(1);
    return r;
  endfunction

  // Driver is off when any of the three sources is active.
  function automatic logic is_hiz(input logic wr, input logic ds, input logic oe);
    return wr | ds | oe;
  endfunction
endpackage

// File: rtl/drvcal_timer.sv
module drvcal_timer #(
  parameter int PERIOD = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == CNT_W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1: evaluation strobe lasts a single cycle
  p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/drvcal_pwrup.sv
module drvcal_pwrup #(
  parameter int SETTLE = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hiz,
  output logic settled,
  output logic done
);
  localparam int PW_W = $clog2(SETTLE + 1);

  logic [PW_W-1:0] pw_cnt;
  logic            hiz_q;
  logic            hiz_rise;

  assign settled  = (pw_cnt == PW_W'(SETTLE));
  assign hiz_rise = hiz & ~hiz_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pw_cnt <= '0;
      hiz_q  <= 1'b1;
      done   <= 1'b0;
    end else begin
      if (!settled) pw_cnt <= pw_cnt + 1'b1;
      hiz_q <= hiz;
      if (settled && hiz_rise) done <= 1'b1;
    end
  end

  // R8: completion only after settling, on a driving-to-off change
  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(settled) && $past(hiz)));
  // R9: completion flag is sticky
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_settled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> settled);
endmodule

// File: rtl/drvcal_code.sv
module drvcal_code
  import drvcal_pkg::*;
#(
  parameter code_t RESET_CODE = code_t'(16)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  hiz,
  input  code_t tgt,
  output code_t code
);
  code_t pend;
  logic  pend_vld;
  code_t nxt;
  logic  do_apply;

  assign nxt      = step_toward(code, tgt);
  assign do_apply = ~tick & hiz & pend_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code     <= RESET_CODE;
      pend     <= RESET_CODE;
      pend_vld <= 1'b0;
    end else if (tick) begin
      pend     <= nxt;
      pend_vld <= (nxt != code);
    end else if (do_apply) begin
      code     <= pend;
      pend_vld <= 1'b0;
    end
  end

  // R2: at most one step per edge, no wrap (R3)
  p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |->
      (({1'b0, code} == {1'b0, $past(code)} + 6'd1) ||
       ({1'b0, code} + 6'd1 == {1'b0, $past(code)})));
  // R4: changes only in an off-window
  p_hiz_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> $past(hiz));
  // R6: never on an evaluation edge
  p_no_tick_apply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> !$past(tick));
  // R2: a prepared step differs by one from the code it was built on
  p_pend_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && pend_vld) |-> (pend != code));
endmodule

// File: rtl/drv_imp_cal.sv
module drv_imp_cal
  import drvcal_pkg::*;
#(
  parameter int EVAL_PERIOD  = 64,
  parameter int PWRUP_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] tgt_code,
  input  logic              wr_cyc,
  input  logic              desel_cyc,
  input  logic              oe_hi,
  output logic [CODE_W-1:0] drv_code,
  output logic              cal_done
);
  logic eval_tick;
  logic hiz;
  logic pw_settled;

  assign hiz = is_hiz(wr_cyc, desel_cyc, oe_hi);

  drvcal_timer #(.PERIOD(EVAL_PERIOD)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (eval_tick)
  );

  drvcal_pwrup #(.SETTLE(PWRUP_CYCLES)) u_pwrup (
    .clk    (clk),
    .rst_n  (rst_n),
    .hiz    (hiz),
    .settled(pw_settled),
    .done   (cal_done)
  );

  drvcal_code u_code (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (eval_tick),
    .hiz  (hiz),
    .tgt  (tgt_code),
    .code (drv_code)
  );

  // R7: reset values visible at the ports
  p_reset_state_r7: assert property (@(posedge clk)
    $past(!rst_n) |-> (drv_code == code_t'(16) && !cal_done));
endmodule

// File: tb/drv_imp_cal_tb.sv
module drv_imp_cal_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] tgt_code = 5'd0;
  logic       wr_cyc = 1'b0, desel_cyc = 1'b0, oe_hi = 1'b0;
  logic [4:0] drv_code;
  logic       cal_done;

  int checks = 0, failures = 0;
  int k = 0;
  int m_code = 16, m_pend = 16, m_done = 0;
  bit m_pv = 0, m_prev = 1;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  drv_imp_cal u_dut (
    .clk(clk), .rst_n(rst_n), .tgt_code(tgt_code), .wr_cyc(wr_cyc),
    .desel_cyc(desel_cyc), .oe_hi(oe_hi), .drv_code(drv_code), .cal_done(cal_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, k);
    end
  endtask

  // One clock: reference update at the edge, comparison at the falling edge.
  task automatic cycle();
    bit hz;
    int nx;
    @(posedge clk);
    if (rst_n) begin
      hz = wr_cyc | desel_cyc | oe_hi;
      k++;
      if (k - 1 >= 4096 && hz && !m_prev) m_done = 1;
      m_prev = hz;
      if (k % 64 == 0) begin
        nx = (tgt_code > m_code) ? m_code + 1 : (tgt_code < m_code) ? m_code - 1 : m_code;
        m_pend = nx;
        m_pv = (nx != m_code);
      end else if (hz && m_pv) begin
        m_code = m_pend;
        m_pv = 0;
      end
    end
    @(negedge clk);
    check("R1 R2 R4 R5 R6 code", drv_code, m_code);
    check("R8 R9 done", cal_done, m_done);
  endtask

  task automatic drive(input bit w, input bit d, input bit o);
    wr_cyc = w; desel_cyc = d; oe_hi = o;
  endtask

  task automatic run_to(input int edge_n);
    while (k < edge_n) cycle();
  endtask

  task automatic run_rand_to(input int edge_n);
    while (k < edge_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0], lfsr[3], lfsr[7]);
      cycle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset code", drv_code, 16);
    check("R7 reset done", cal_done, 0);
    rst_n = 1'b1;
    // R5: driving stretch, step prepared at edge 64 must wait
    tgt_code = 5'd20;
    drive(0, 0, 0);
    run_to(200);
    check("R5 held while driving", drv_code, 16);
    // R4: single off-window via output enable
    drive(0, 0, 1);
    run_to(201);
    check("R4 applied in window", drv_code, 17);
    drive(0, 0, 0);
    run_to(255);
    // R6: window exactly on evaluation edge 256
    drive(1, 0, 0);
    run_to(256);
    check("R6 no apply on eval edge", drv_code, 17);
    drive(0, 1, 0);
    run_to(257);
    check("R6 applied after eval edge", drv_code, 18);
    // R3: saturation at top
    tgt_code = 5'd31;
    run_rand_to(3900);
    check("R3 saturates high", drv_code, 31);
    check("R8 not done before settle", cal_done, 0);
    // R8: window held high across the end of settling does not count
    drive(0, 0, 1);
    run_to(4300);
    check("R8 held window no done", cal_done, 0);
    check("R3 stays at 31", drv_code, 31);
    drive(0, 0, 0);
    run_to(4301);
    drive(1, 0, 0);
    run_to(4302);
    check("R8 done on rising window", cal_done, 1);
    // R3/R9: saturation at bottom, flag stays
    tgt_code = 5'd0;
    run_rand_to(7000);
    check("R3 saturates low", drv_code, 0);
    check("R9 done sticky", cal_done, 1);
    // R2: converge and hold at a middle target
    tgt_code = 5'd9;
    run_rand_to(7700);
    check("R2 settles at target", drv_code, 9);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule